// File: doc/BRIEF.md
# Byte-Serial Unsigned 16x16 Multiplier

This block multiplies two unsigned operands through a single byte-by-byte multiplier. It never uses a full-width array multiplier. The operands are split into bytes, with the least significant byte at index 0. The block walks through the byte pairs in two nested loops:

- The outer loop selects a byte of the second operand.
- The inner loop selects a byte of the first operand.

Each byte product is folded into a byte-indexed result register at an offset that slides upward. The fold is three byte-wide additions: the low half of the product, then the high half with the carry, then the carry alone one byte further up. Any carry beyond the top byte of the result is discarded; by arithmetic it is always zero.

Operation is controlled by plain handshake pins. A `start` pulse while the block is idle captures both operands and clears the result register. `busy` is high for the whole computation. `done` pulses for one cycle when the product is complete. The product stays on its port until the next accepted start.

With the default parameters the block is 16x16 to 32 bits. There are four byte steps of three cycles each.

Top module: `byte_serial_mul`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy` and `done` are low and `product` is zero.
- R2: A `start` sampled high while `busy` is low captures `a_in` and `b_in`. In the following cycle `busy` is high and `product` reads zero.
- R3: `busy` stays high for exactly 12 cycles (3 cycles for each of the 4 byte pairs). In the cycle after the last busy cycle, `done` is high for exactly one cycle. `done` and `busy` are never high together.
- R4: When `done` is high, `product` equals the unsigned 32-bit product of the captured operands, for example 0x000C x 0x020F = 0x000018B4 and 0xFFFF x 0xFFFF = 0xFFFE0001.
- R5: The four steps take the byte pairs in this order: (a byte 0, b byte 0), (a byte 1, b byte 0), (a byte 0, b byte 1), (a byte 1, b byte 1). Each step adds a_byte x b_byte, shifted left by 8 x (a index + b index) bits, into the result. After each 3-cycle step, `product` equals the running sum of the steps taken so far.
- R6: `start`, `a_in` and `b_in` have no effect while `busy` is high. The final product is that of the operands captured at the accepted start.
- R7: While idle and with `start` low, `product` holds its value and `done` does not repeat, whatever `a_in` and `b_in` do.
- R8: A carry that would go beyond the most significant result byte is dropped, and it is always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a multiplication; honoured only while not busy |
| a_in | input | 16 | First operand, byte 0 least significant |
| b_in | input | 16 | Second operand, byte 0 least significant |
| busy | output | 1 | High while a multiplication is in progress |
| done | output | 1 | One-cycle pulse when the product is final |
| product | output | 32 | Result register, little-endian bytes |

## Verification
The assertions assume the operands of interest are present on `a_in` and `b_in` in the cycle `start` is accepted. They assume nothing about those pins at any other time. For that reason the bench scrambles `a_in`, `b_in` and `start` during busy windows and during idle stretches. The assertions also assume `start` is a synchronous level that may be held high at any time. The stimulus raises it in the middle of runs so that the ignore rule is exercised.

The operand sweep is a grid of corner values and spread patterns. It includes all-ones operands, which drive every byte addition to its carry limit. The bench computes expected results by plain integer multiplication and by summing shifted byte products.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  // Sub-cycle of one byte-pair step; IDLE means no work in flight.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LO   = 2'd1,
    PH_HI   = 2'd2,
    PH_CY   = 2'd3
  } phase_e;
endpackage

// File: rtl/bsm_byte_mul.sv
module bsm_byte_mul #(
  parameter int W = 8
) (
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [2*W-1:0] p
);
  // Shift-and-add expansion of the single narrow multiplier.
  always_comb begin
    p = '0;
    for (int n = 0; n < W; n++) begin
      if (y[n]) p = p + ({{W{1'b0}}, x} << n);
    end
  end
endmodule

// File: rtl/bsm_ctrl.sv
module bsm_ctrl
  import bsm_pkg::*;
#(
  parameter int NB = 2,
  parameter int IW = (NB > 1) ? $clog2(NB) : 1,
  parameter int KW = $clog2(2 * NB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output phase_e        phase,
  output logic [IW-1:0] i_idx,
  output logic [IW-1:0] j_idx,
  output logic [KW-1:0] k_off,
  output logic          load,
  output logic          busy,
  output logic          done
);
  localparam logic [IW-1:0] LAST     = IW'(NB - 1);
  localparam logic [KW-1:0] BACK     = KW'(NB - 1);
  localparam int            RUN_CYC  = 3 * NB * NB;
  localparam int            CW       = $clog2(RUN_CYC + 2);

  phase_e phase_q;

  assign phase = phase_q;
  assign busy  = (phase_q != PH_IDLE);
  assign load  = (phase_q == PH_IDLE) && start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      i_idx   <= '0;
      j_idx   <= '0;
      k_off   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q <= PH_LO;
            i_idx   <= '0;
            j_idx   <= '0;
            k_off   <= '0;
          end
        end
        PH_LO: phase_q <= PH_HI;
        PH_HI: phase_q <= PH_CY;
        PH_CY: begin
          if (j_idx == LAST) begin
            // window advances one, then backs off so the next row starts one byte higher
            j_idx <= '0;
            k_off <= k_off + KW'(1) - BACK;
            if (i_idx == LAST) begin
              phase_q <= PH_IDLE;
              i_idx   <= '0;
              done    <= 1'b1;
            end else begin
              phase_q <= PH_LO;
              i_idx   <= i_idx + IW'(1);
            end
          end else begin
            phase_q <= PH_LO;
            j_idx   <= j_idx + IW'(1);
            k_off   <= k_off + KW'(1);
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // Run-length observer for the busy window.
  logic [CW-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (load) run_len <= '0;
    else if (busy) run_len <= run_len + CW'(1);
  end

  // R3
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));
  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_len == CW'(RUN_CYC)));
  // R5
  window_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (k_off == (KW'(i_idx) + KW'(j_idx))));
endmodule

// File: rtl/bsm_accum.sv
module bsm_accum
  import bsm_pkg::*;
#(
  parameter int W  = 8,
  parameter int NB = 2,
  parameter int KW = $clog2(2 * NB + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  phase_e            phase,
  input  logic [KW-1:0]     k_off,
  input  logic [2*W-1:0]    pp,
  output logic [2*NB*W-1:0] acc
);
  localparam int RB = 2 * NB;

  logic [W-1:0] byte_q [RB];
  logic         carry_q;

  logic [KW-1:0] tgt;
  logic          wr_en;
  logic [W-1:0]  cur;
  logic [W-1:0]  addend;
  logic          cin;
  logic [W:0]    sum;

  always_comb begin
    tgt    = k_off;
    addend = '0;
    cin    = 1'b0;
    unique case (phase)
      PH_LO: begin tgt = k_off;           addend = pp[W-1:0]; cin = 1'b0;    end
      PH_HI: begin tgt = k_off + KW'(1);  addend = pp[2*W-1:W]; cin = carry_q; end
      PH_CY: begin tgt = k_off + KW'(2);  addend = '0;        cin = carry_q; end
      default: ;
    endcase
    wr_en = (phase != PH_IDLE) && (tgt < KW'(RB));
    cur = '0;
    for (int b = 0; b < RB; b++) begin
      if (tgt == KW'(b)) cur = byte_q[b];
    end
    sum = {1'b0, cur} + {1'b0, addend} + {{W{1'b0}}, cin};
  end

  for (genvar b = 0; b < RB; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           byte_q[b] <= '0;
      else if (clear)                       byte_q[b] <= '0;
      else if (wr_en && (tgt == KW'(b)))    byte_q[b] <= sum[W-1:0];
    end
    assign acc[b*W +: W] = byte_q[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               carry_q <= 1'b0;
    else if (clear)           carry_q <= 1'b0;
    else if (phase == PH_CY)  carry_q <= 1'b0;
    else if (phase != PH_IDLE) carry_q <= sum[W];
  end

  // R8
  top_carry_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_CY) && !(tgt < KW'(RB))) |-> !carry_q);
  // R8
  carry_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LO) |-> !carry_q);
endmodule

// File: rtl/byte_serial_mul.sv
module byte_serial_mul
  import bsm_pkg::*;
#(
  parameter int W  = 8,
  parameter int NB = 2,
  localparam int OW = NB * W,
  localparam int PW = 2 * NB * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [OW-1:0] a_in,
  input  logic [OW-1:0] b_in,
  output logic          busy,
  output logic          done,
  output logic [PW-1:0] product
);
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;
  localparam int KW = $clog2(2 * NB + 1);

  phase_e        phase;
  logic [IW-1:0] i_idx;
  logic [IW-1:0] j_idx;
  logic [KW-1:0] k_off;
  logic          load;
  logic [OW-1:0] op_a;
  logic [OW-1:0] op_b;
  logic [W-1:0]  a_byte;
  logic [W-1:0]  b_byte;
  logic [2*W-1:0] pp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_a <= '0;
      op_b <= '0;
    end else if (load) begin
      op_a <= a_in;
      op_b <= b_in;
    end
  end

  assign a_byte = op_a[j_idx*W +: W];
  assign b_byte = op_b[i_idx*W +: W];

  bsm_ctrl #(.NB(NB), .IW(IW), .KW(KW)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .phase (phase),
    .i_idx (i_idx),
    .j_idx (j_idx),
    .k_off (k_off),
    .load  (load),
    .busy  (busy),
    .done  (done)
  );

  bsm_byte_mul #(.W(W)) u_bmul (
    .x (a_byte),
    .y (b_byte),
    .p (pp)
  );

  bsm_accum #(.W(W), .NB(NB), .KW(KW)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (load),
    .phase (phase),
    .k_off (k_off),
    .pp    (pp),
    .acc   (product)
  );

  // R4
  final_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (product == (PW'(op_a) * PW'(op_b))));
  // R6
  ops_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(op_a) && $stable(op_b)));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));
  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && (product == '0)));
endmodule

// File: tb/byte_serial_mul_bench.sv
`timescale 1ns/1ps
module byte_serial_mul_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] a = '0;
  logic [15:0] b = '0;
  logic        busy;
  logic        done;
  logic [31:0] product;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  byte_serial_mul u_byte_serial_mul (
    .clk(clk), .rst_n(rst_n), .start(start), .a_in(a), .b_in(b),
    .busy(busy), .done(done), .product(product)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pick(input int n);
    case (n)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h00FF;
      3: return 16'h0100;
      4: return 16'hFFFF;
      5: return 16'h8000;
      6: return 16'hFF00;
      7: return 16'h0101;
      default: return 16'((n * 40503) ^ (n << 11));
    endcase
  endfunction

  // One full multiplication; poke raises start with junk operands mid-run (R6).
  task automatic run(input logic [15:0] av, input logic [15:0] bv, input bit poke);
    logic [31:0] run_sum;
    logic [31:0] full;
    bit          busy_ok;
    int          n;
    run_sum = '0;
    full    = 32'(av) * 32'(bv);
    busy_ok = 1'b1;
    @(negedge clk);
    a = av; b = bv; start = 1'b1;
    @(negedge clk);
    start = 1'b0; a = ~av; b = bv ^ 16'h5A5A;
    n = 1;
    chk(busy === 1'b1, "R2 busy after start", 32'(busy), 32'd1);
    chk(product === 32'd0, "R2 product cleared", product, 32'd0);
    for (int s = 0; s < 4; s++) begin
      int bi;
      int aj;
      bi = s / 2;
      aj = s % 2;
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        n++;
        if (poke && n == 5) begin start = 1'b1; a = 16'hA5C3; b = 16'h3C5A; end
        if (poke && n == 6) start = 1'b0;
        if (n <= 12 && (busy !== 1'b1 || done !== 1'b0)) busy_ok = 1'b0;
      end
      run_sum = run_sum + ((32'(av[aj*8 +: 8]) * 32'(bv[bi*8 +: 8])) << (8 * (aj + bi)));
      if (s < 3) chk(product === run_sum, "R5 running sum after step", product, run_sum);
    end
    chk(busy_ok, "R3 busy held 12 cycles without done", 32'(busy_ok), 32'd1);
    chk(busy === 1'b0 && done === 1'b1, "R3 done pulse as busy falls", {30'd0, busy, done}, 32'd1);
    chk(product === full, poke ? "R6 product of captured operands" : "R4 final product", product, full);
    @(negedge clk);
    a = av ^ 16'hFFFF;
    chk(done === 1'b0 && product === full, "R7 held after done", product, full);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state, during and after
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && product === 32'd0, "R1 reset", product, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && product === 32'd0, "R1 after reset", product, 32'd0);

    // R4 directed vectors
    run(16'h000C, 16'h020F, 1'b0);
    chk(product === 32'h000018B4, "R4 vector 0x000C*0x020F", product, 32'h000018B4);
    // R8: all-ones stresses every carry up to the top byte
    run(16'hFFFF, 16'hFFFF, 1'b0);
    chk(product === 32'hFFFE0001, "R8 all-ones product", product, 32'hFFFE0001);

    // R7: idle stretch with moving operands
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      a = 16'(t * 4099); b = 16'(t * 771);
      chk(product === 32'hFFFE0001 && done === 1'b0, "R7 idle hold", product, 32'hFFFE0001);
    end

    // R4/R5/R6 operand grid sweep
    for (int ia = 0; ia < 24; ia++) begin
      for (int ib = 0; ib < 24; ib++) begin
        run(pick(ia), pick(ib), ((ia + ib) % 7) == 0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule